// File: doc/BRIEF.md
# Register-Mapped Interrupt Controller

This block collects up to 32 interrupt inputs into a single request line for a processor. Software reaches it through a plain register bus of eight 32-bit words. There is one write strobe, a word-aligned byte address and write data. Read data is returned combinationally from the address in the same cycle. The bus carries single register accesses and not a data stream, so it uses no valid/ready handshake. The bus has no back-pressure: every write strobe completes in the cycle it is asserted.

Each input passes through a two-flop synchroniser. An elaboration-time mask then marks it as edge-captured or level-captured. Captured activity sets bits in a status word. The status word is masked by an enable word to give the pending word. The lowest-numbered pending input is encoded as a vector. The request output is raised when pending is nonzero and the output gate is on.

A two-bit master-control word sets the operating mode. Its low bit gates the request output. Its high bit turns on hardware capture, and while that bit is set, software cannot write the status word directly. Acknowledge, set-enable and clear-enable are write-only action words. They read back as zero.

Top module: `irq_ctrl`

## Requirements
- R1: The word index is address bits [4:2] and maps as follows: 0 status, 1 pending, 2 enable, 3 acknowledge, 4 set-enable, 5 clear-enable, 6 vector, 7 master-control. An address with nonzero bits [1:0], or at byte 0x20 or above, is not decoded: a write to it has no effect and a read of it returns zero. Reads of acknowledge, set-enable and clear-enable return zero.
- R2: After reset, status, enable and master-control are zero, the vector reads 0xFFFFFFFF and the request output is low. Pending always reads as status AND enable.
- R3: The vector reads the index of the lowest set pending bit, zero-extended. When pending is zero it reads 0xFFFFFFFF.
- R4: The request output is high exactly when master-control bit 0 is 1 and pending is nonzero.
- R5: A write to acknowledge clears every status bit whose data bit is 1 and leaves the other status bits unchanged.
- R6: A write to enable loads it. A write to set-enable ORs the data into enable. A write to clear-enable clears the enable bits whose data bit is 1.
- R7: A write to master-control stores data bits [1:0] and discards the rest.
- R8: A write to status loads it when master-control bit 1 is 0. The write is ignored when master-control bit 1 is 1.
- R9: While master-control bit 1 is 0, input activity never changes status.
- R10: With capture on, a level-type input (mask bit 0) that is high sets its status bit on every clock. The bit first shows after the third rising edge that samples the input high, and an acknowledge cannot clear it while the input stays high.
- R11: With capture on, an edge-type input (mask bit 1) sets its status bit once per low-to-high transition. After an acknowledge, the bit stays clear while the input remains high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_addr | input | ADDR_W | Byte address of the register word |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr, combinational |
| irq_in | input | NUM_IN | Asynchronous interrupt inputs |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The hardest cases to reach from the ports are a capture and an acknowledge that meet on the same clock, and a write to status that the lock should suppress. Both require the inputs and the mode bits to be placed deliberately and the synchroniser latency to be counted. The bench holds a level input high and acknowledges it, which shows that the bit cannot be cleared. It acknowledges an edge input while that input is still high, which shows that the bit does not return. It writes status while the lock is on. Pending, vector and the request output are checked by a full sweep of all status values against several enable masks in a small eight-input configuration.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned WORD_LSB  = 2;
  localparam int unsigned SEL_W     = 3;
  localparam int unsigned MCTL_W    = 2;
  localparam int unsigned MCTL_OUT  = 0;
  localparam int unsigned MCTL_CAP  = 1;

  typedef enum logic [SEL_W-1:0] {
    SEL_STATUS = 3'd0,
    SEL_PEND   = 3'd1,
    SEL_ENABLE = 3'd2,
    SEL_ACK    = 3'd3,
    SEL_SETEN  = 3'd4,
    SEL_CLREN  = 3'd5,
    SEL_VEC    = 3'd6,
    SEL_MCTL   = 3'd7
  } reg_sel_e;
endpackage

// File: rtl/irqc_sync_capture.sv
module irqc_sync_capture #(
  parameter int unsigned NUM_IN = 32,
  parameter logic [NUM_IN-1:0] EDGE_MASK = '0,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_IN-1:0] pin_i,
  output logic [NUM_IN-1:0] req_o
);
  logic [NUM_IN-1:0] stage_q [SYNC_STAGES];
  logic [NUM_IN-1:0] synced;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < SYNC_STAGES; k++) stage_q[k] <= '0;
    end else begin
      stage_q[0] <= pin_i;
      for (int k = 1; k < SYNC_STAGES; k++) stage_q[k] <= stage_q[k-1];
    end
  end

  assign synced = stage_q[SYNC_STAGES-1];

  // per-input capture kind chosen at elaboration
  for (genvar g = 0; g < NUM_IN; g++) begin : g_kind
    if (EDGE_MASK[g]) begin : g_edge
      logic prev_q;
      always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= synced[g];
      end
      assign req_o[g] = synced[g] & ~prev_q;
    end else begin : g_level
      assign req_o[g] = synced[g];
    end
  end
endmodule

// File: rtl/irqc_regfile.sv
module irqc_regfile
  import irqc_pkg::*;
#(
  parameter int unsigned NUM_IN = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  reg_sel_e          wr_sel,
  input  logic [NUM_IN-1:0] wr_data,
  input  logic [MCTL_W-1:0] wr_mctl,
  input  logic [NUM_IN-1:0] cap_req,
  output logic [NUM_IN-1:0] status_o,
  output logic [NUM_IN-1:0] enable_o,
  output logic [MCTL_W-1:0] mctl_o
);
  logic [NUM_IN-1:0] status_q, status_nx;
  logic [NUM_IN-1:0] enable_q, enable_nx;
  logic [MCTL_W-1:0] mctl_q, mctl_nx;

  always_comb begin
    status_nx = status_q;
    enable_nx = enable_q;
    mctl_nx   = mctl_q;
    if (wr_en) begin
      unique case (wr_sel)
        SEL_STATUS: if (!mctl_q[MCTL_CAP]) status_nx = wr_data;
        SEL_ACK:    status_nx = status_q & ~wr_data;
        SEL_ENABLE: enable_nx = wr_data;
        SEL_SETEN:  enable_nx = enable_q | wr_data;
        SEL_CLREN:  enable_nx = enable_q & ~wr_data;
        SEL_MCTL:   mctl_nx   = wr_mctl;
        default: ;
      endcase
    end
    // capture after software effects, so a held level wins over an ack
    if (mctl_q[MCTL_CAP]) status_nx = status_nx | cap_req;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      enable_q <= '0;
      mctl_q   <= '0;
    end else begin
      status_q <= status_nx;
      enable_q <= enable_nx;
      mctl_q   <= mctl_nx;
    end
  end

  assign status_o = status_q;
  assign enable_o = enable_q;
  assign mctl_o   = mctl_q;
endmodule

// File: rtl/irqc_prio_enc.sv
module irqc_prio_enc #(
  parameter int unsigned NUM_IN = 32,
  parameter int unsigned IDX_W  = $clog2(NUM_IN)
) (
  input  logic [NUM_IN-1:0] req_i,
  output logic              any_o,
  output logic [IDX_W-1:0]  idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = NUM_IN - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end
  assign any_o = |req_i;
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irqc_pkg::*;
#(
  parameter int unsigned NUM_IN      = 32,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned ADDR_W      = 5,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [NUM_IN-1:0] EDGE_MASK = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NUM_IN-1:0] irq_in,
  output logic              irq_out
);
  localparam int unsigned IDX_W = $clog2(NUM_IN);

  logic              addr_ok;
  reg_sel_e          sel;
  logic [NUM_IN-1:0] cap_req, status_q, enable_q, pend_w;
  logic [MCTL_W-1:0] mctl_q;
  logic              pend_any;
  logic [IDX_W-1:0]  pend_idx;
  logic [DATA_W-1:0] vec_word;

  assign addr_ok = (bus_addr[WORD_LSB-1:0] == '0) &&
                   ((bus_addr >> (WORD_LSB + SEL_W)) == '0);
  assign sel     = reg_sel_e'(bus_addr[WORD_LSB+SEL_W-1:WORD_LSB]);

  irqc_sync_capture #(
    .NUM_IN(NUM_IN), .EDGE_MASK(EDGE_MASK), .SYNC_STAGES(SYNC_STAGES)
  ) cap_i (
    .clk(clk), .rst(rst), .pin_i(irq_in), .req_o(cap_req)
  );

  irqc_regfile #(.NUM_IN(NUM_IN)) regs_i (
    .clk(clk), .rst(rst),
    .wr_en(bus_wr && addr_ok), .wr_sel(sel),
    .wr_data(bus_wdata[NUM_IN-1:0]), .wr_mctl(bus_wdata[MCTL_W-1:0]),
    .cap_req(cap_req),
    .status_o(status_q), .enable_o(enable_q), .mctl_o(mctl_q)
  );

  assign pend_w = status_q & enable_q;

  irqc_prio_enc #(.NUM_IN(NUM_IN), .IDX_W(IDX_W)) enc_i (
    .req_i(pend_w), .any_o(pend_any), .idx_o(pend_idx)
  );

  assign vec_word = pend_any ? DATA_W'(pend_idx) : '1;
  assign irq_out  = mctl_q[MCTL_OUT] & pend_any;

  always_comb begin
    bus_rdata = '0;
    if (addr_ok) begin
      unique case (sel)
        SEL_STATUS: bus_rdata = DATA_W'(status_q);
        SEL_PEND:   bus_rdata = DATA_W'(pend_w);
        SEL_ENABLE: bus_rdata = DATA_W'(enable_q);
        SEL_VEC:    bus_rdata = vec_word;
        SEL_MCTL:   bus_rdata = DATA_W'(mctl_q);
        default:    bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk
  import irqc_pkg::*;
#(
  parameter int unsigned NUM_IN = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [NUM_IN-1:0] status_q,
  input logic [NUM_IN-1:0] enable_q,
  input logic [NUM_IN-1:0] pend_w,
  input logic [MCTL_W-1:0] mctl_q,
  input logic [DATA_W-1:0] vec_word,
  input logic              irq_out
);
  localparam int unsigned IDX_W = $clog2(NUM_IN);

  logic [NUM_IN-1:0] wd;
  logic w_stat, w_ack, w_set, w_clr, w_mctl;
  assign wd     = bus_wdata[NUM_IN-1:0];
  assign w_stat = bus_wr && bus_addr == ADDR_W'(int'(SEL_STATUS) * 4);
  assign w_ack  = bus_wr && bus_addr == ADDR_W'(int'(SEL_ACK) * 4);
  assign w_set  = bus_wr && bus_addr == ADDR_W'(int'(SEL_SETEN) * 4);
  assign w_clr  = bus_wr && bus_addr == ADDR_W'(int'(SEL_CLREN) * 4);
  assign w_mctl = bus_wr && bus_addr == ADDR_W'(int'(SEL_MCTL) * 4);

  // R3
  vec_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (pend_w == '0) |-> (vec_word == '1));
  // R3
  vec_lowest_chk: assert property (@(posedge clk) disable iff (rst)
    (pend_w != '0) |-> ((vec_word >> IDX_W) == '0 && pend_w[vec_word[IDX_W-1:0]] &&
      (pend_w & ~({NUM_IN{1'b1}} << vec_word[IDX_W-1:0])) == '0));
  // R4
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !mctl_q[MCTL_OUT] |-> !irq_out);
  // R4
  irq_raise_chk: assert property (@(posedge clk) disable iff (rst)
    (mctl_q[MCTL_OUT] && (status_q & enable_q) != '0) |-> irq_out);
  // R5
  ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (w_ack && !mctl_q[MCTL_CAP]) |=> ((status_q & $past(wd)) == '0));
  // R6
  set_en_chk: assert property (@(posedge clk) disable iff (rst)
    w_set |=> ((enable_q & $past(wd)) == $past(wd)));
  // R6
  clr_en_chk: assert property (@(posedge clk) disable iff (rst)
    w_clr |=> ((enable_q & $past(wd)) == '0));
  // R7
  mctl_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !w_mctl |=> $stable(mctl_q));
  // R8
  stat_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (w_stat && mctl_q[MCTL_CAP]) |=> ((status_q & $past(status_q)) == $past(status_q)));
  // R9
  no_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (!mctl_q[MCTL_CAP] && !w_stat && !w_ack) |=> $stable(status_q));
endmodule

bind irq_ctrl irqc_chk #(.NUM_IN(NUM_IN), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .status_q(status_q), .enable_q(enable_q), .pend_w(pend_w), .mctl_q(mctl_q),
  .vec_word(vec_word), .irq_out(irq_out)
);

// File: tb/irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_ctrl_tb_top;
  localparam int NI = 8;
  localparam int AW = 6;
  localparam int DW = 32;
  localparam logic [NI-1:0] EM = 8'hF0;   // inputs 4..7 edge, 0..3 level
  localparam logic [AW-1:0] A_STAT = 6'h00, A_PEND = 6'h04, A_EN = 6'h08, A_ACK = 6'h0C,
                            A_SET = 6'h10, A_CLR = 6'h14, A_VEC = 6'h18, A_MC = 6'h1C;

  logic clk = 1'b0, rst = 1'b1, bus_wr = 1'b0, irq_out;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0, bus_rdata;
  logic [NI-1:0] irq_in = '0;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  irq_ctrl #(.NUM_IN(NI), .DATA_W(DW), .ADDR_W(AW), .SYNC_STAGES(2), .EDGE_MASK(EM)) dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_in(irq_in), .irq_out(irq_out));

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(string tag, logic [AW-1:0] a, logic [31:0] exp);
    bus_addr = a;
    #1;
    check(tag, bus_rdata, exp);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] exp_vec(logic [NI-1:0] p);
    logic [31:0] v = 32'hFFFF_FFFF;
    for (int i = NI - 1; i >= 0; i--) if (p[i]) v = i;
    return v;
  endfunction

  initial begin
    #(5.0 * 200000);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    idle(4);
    rst = 1'b0;
    idle(1);
    // R2 reset state, R1 action words read zero
    rd_chk("R2 status", A_STAT, 0);
    rd_chk("R2 pend", A_PEND, 0);
    rd_chk("R2 enable", A_EN, 0);
    rd_chk("R1 ack reads 0", A_ACK, 0);
    rd_chk("R1 set reads 0", A_SET, 0);
    rd_chk("R1 clr reads 0", A_CLR, 0);
    rd_chk("R2 vec", A_VEC, 32'hFFFF_FFFF);
    rd_chk("R2 mctl", A_MC, 0);
    check("R2 irq_out", {31'b0, irq_out}, 0);

    // R7 only two bits kept
    wr(A_MC, 32'hFFFF_FFFF);
    rd_chk("R7 mctl", A_MC, 3);
    wr(A_MC, 32'h0000_0005);
    rd_chk("R7 mctl low bits", A_MC, 1);

    // R2 R3 R4 R8 sweep with capture off
    for (int e = 0; e < 4; e++) begin
      logic [NI-1:0] en;
      en = (e == 0) ? 8'hFF : (e == 1) ? 8'h00 : (e == 2) ? 8'hA5 : 8'h0F;
      wr(A_EN, {24'b0, en});
      rd_chk("R6 enable load", A_EN, {24'b0, en});
      for (int s = 0; s < 256; s++) begin
        wr(A_STAT, s);
        rd_chk("R8 status load", A_STAT, s);
        rd_chk("R2 pend", A_PEND, s & en);
        rd_chk("R3 vec", A_VEC, exp_vec(s[NI-1:0] & en));
        check("R4 irq_out", {31'b0, irq_out}, {31'b0, (s[NI-1:0] & en) != 0});
      end
    end
    wr(A_MC, 0);
    check("R4 irq gated off", {31'b0, irq_out}, 0);
    rd_chk("R3 vec gate-independent", A_VEC, 0);

    // R5 acknowledge
    wr(A_STAT, 32'hFF);
    wr(A_ACK, 32'h5A);
    rd_chk("R5 ack", A_STAT, 32'hA5);
    // R6 set / clear enable
    wr(A_EN, 32'h11);
    wr(A_SET, 32'h0C);
    rd_chk("R6 set-enable", A_EN, 32'h1D);
    wr(A_CLR, 32'h05);
    rd_chk("R6 clear-enable", A_EN, 32'h18);

    // R1 undecoded addresses
    wr(A_MC, 1);
    wr(A_STAT, 32'h22);
    wr(6'h01, 32'h00);
    rd_chk("R1 misaligned write ignored", A_STAT, 32'h22);
    wr(6'h20, 32'h00);
    rd_chk("R1 high write ignored", A_STAT, 32'h22);
    rd_chk("R1 misaligned read", 6'h0A, 0);
    rd_chk("R1 high read", 6'h20, 0);

    // R9 no capture while bit 1 clear
    wr(A_STAT, 0);
    irq_in = 8'hFF;
    idle(6);
    rd_chk("R9 no capture", A_STAT, 0);
    irq_in = 8'h00;
    idle(5);

    // R10 level capture and latency
    wr(A_MC, 3);
    idle(3);
    rd_chk("R10 quiet", A_STAT, 0);
    irq_in = 8'h02;
    @(negedge clk); @(negedge clk);
    rd_chk("R10 not yet after two edges", A_STAT, 0);
    @(negedge clk);
    rd_chk("R10 set after third edge", A_STAT, 32'h02);
    wr(A_ACK, 32'h02);
    rd_chk("R10 level re-asserts over ack", A_STAT, 32'h02);
    irq_in = 8'h00;
    idle(4);
    wr(A_ACK, 32'h02);
    rd_chk("R10 clears once low", A_STAT, 0);

    // R11 edge capture
    irq_in = 8'h10;
    idle(5);
    rd_chk("R11 edge captured", A_STAT, 32'h10);
    wr(A_ACK, 32'h10);
    idle(5);
    rd_chk("R11 no recapture while high", A_STAT, 0);
    irq_in = 8'h00;
    idle(4);
    irq_in = 8'h10;
    idle(5);
    rd_chk("R11 new edge captured", A_STAT, 32'h10);
    wr(A_EN, 32'h10);
    rd_chk("R3 vec edge input", A_VEC, 4);
    check("R4 irq from edge input", {31'b0, irq_out}, 1);

    // R8 status locked while capturing
    wr(A_STAT, 32'h00);
    rd_chk("R8 locked clear", A_STAT, 32'h10);
    wr(A_STAT, 32'hEF);
    rd_chk("R8 locked set", A_STAT, 32'h10);
    wr(A_MC, 1);
    wr(A_STAT, 32'h22);
    rd_chk("R8 unlocked load", A_STAT, 32'h22);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule